// File: doc/BRIEF.md
# Receive Page Ring Manager

This block keeps track of a circular receive buffer that lives in a local packet memory divided into 256-byte pages. Two configuration values bound the ring: the first page that belongs to it and the page just past its end. A write pointer (`current`) names the next free page that an arriving frame will fill. A read pointer (`boundary`) names the oldest packet that has not been read yet. The receive path reports each stored frame as a number of pages. The block moves `current` forward by that number, wraps it at the ring's end, and refuses any frame that would overwrite unread data. When it refuses a frame it raises a sticky overflow flag.

Every stored packet starts with a four-byte header. The header carries a status byte, the page where the following packet begins, and a 16-bit byte count. A single send-packet pulse starts an automatic removal. The block reads the header at the page named by `boundary` and hands a DMA engine a start address of `boundary` followed by a zero byte. It also hands over the byte count taken from the header. When the DMA engine signals completion, the block moves `boundary` to the next-page value from the header. Software keeps issuing send-packet until the ring reports empty.

Top module: `rxr_ring_mgr`

## Requirements
- R1: After reset, the first ring page is RST_START (0x26) and the end page is RST_STOP (0x40). Both `boundary` and `current` equal RST_START. `empty` is 1, and `overflow`, `busy`, `hdr_req` and `dma_start` are 0.
- R2: A `ring_init` pulse loads the first and end pages from `init_start` and `init_stop`. It sets both `boundary` and `current` to `init_start`, clears `overflow` and abandons any send-packet in progress, all at the next edge. It takes priority over every other input.
- R3: `empty` is 1 exactly when `boundary` equals `current`.
- R4: An accepted `frm_commit` of n pages moves `current` to current+n at the next edge. If that sum reaches or passes the end page, `current` becomes start + (sum − end page).
- R5: Free space is (boundary − current) modulo the ring size, and counts as the whole ring when the ring is empty. A commit whose n is greater than or equal to the free space is refused: `current` is unchanged and `overflow` is set. `overflow` stays set until an `ovf_clr` pulse or `ring_init`. When a refusal and `ovf_clr` fall in the same cycle, the refusal wins.
- R6: A `sp_cmd` pulse, given while idle and not empty, raises `busy` at the next edge. `hdr_req` then holds with `hdr_addr` = {boundary, 8'h00} until `hdr_valid`.
- R7: The header word `hdr_data` holds byte 0 in bits 7:0 (status), byte 1 in bits 15:8 (next page), byte 2 in bits 23:16 (count low) and byte 3 in bits 31:24 (count high). The cycle after `hdr_valid`, `dma_start` pulses for one cycle. During that pulse `dma_addr` = {boundary, 8'h00} and `dma_count` = {byte 3, byte 2}.
- R8: After the `dma_start` pulse, a `dma_done` pulse sets `boundary` to the header's next-page byte and drops `busy` at the next edge.
- R9: A `sp_cmd` given while the ring is empty, or while a send-packet is already running, is ignored. It sets no busy state, requests no header and starts no DMA.
- R10: When a commit arrives in the same cycle as the `dma_done` that moves `boundary`, the free space for that commit is judged against the `boundary` value before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_init | input | 1 | Load ring bounds and reset both pointers |
| init_start | input | 8 | First page of the ring, used with ring_init |
| init_stop | input | 8 | Page just past the ring, used with ring_init |
| frm_commit | input | 1 | A received frame has been stored |
| frm_pages | input | 8 | Pages taken by the committed frame |
| ovf_clr | input | 1 | Clear the overflow flag |
| sp_cmd | input | 1 | Send-packet request |
| hdr_req | output | 1 | Header read request |
| hdr_addr | output | 16 | Byte address of the header |
| hdr_valid | input | 1 | Header word is valid |
| hdr_data | input | 32 | Header word, byte 0 in the low bits |
| dma_start | output | 1 | One-cycle DMA launch |
| dma_addr | output | 16 | DMA start byte address |
| dma_count | output | 16 | DMA byte count |
| dma_done | input | 1 | DMA finished |
| busy | output | 1 | Send-packet in progress |
| empty | output | 1 | Ring holds no unread packet |
| overflow | output | 1 | Sticky overflow flag |
| boundary | output | 8 | Read pointer page |
| current | output | 8 | Write pointer page |

## Verification
Two actions can land in the same cycle: the end of a send-packet, which moves `boundary`, and a frame commit, which tests free space against `boundary`. The bench creates this case by raising `frm_commit` together with `dma_done`. It picks a page count that fits only if the new `boundary` were used, so the refusal and the unchanged `current` show that the old value was used. A behavioural model computes the expected result at every edge, and every output is compared with it at every clock.

// File: rtl/rxr_pkg.sv
// Shared types for the receive page ring manager.
package rxr_pkg;
    // Send-packet sequencer states
    typedef enum logic [1:0] {
        SP_IDLE   = 2'd0,
        SP_HDR    = 2'd1,
        SP_LAUNCH = 2'd2,
        SP_WAIT   = 2'd3
    } sp_state_e;

    // Packet header as one word; byte 0 sits in the low bits
    typedef struct packed {
        logic [7:0] cnt_hi;
        logic [7:0] cnt_lo;
        logic [7:0] next_pg;
        logic [7:0] rx_stat;
    } rx_hdr_t;
endpackage

// File: rtl/rxr_ring_space.sv
// rxr_ring_space: combinational free-space test and wrapped advance of the
// write pointer. Assumes ring_stop > ring_start and both pointers in range.
module rxr_ring_space #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] ring_start,
    input  logic [PAGE_W-1:0] ring_stop,
    input  logic [PAGE_W-1:0] bnd,
    input  logic [PAGE_W-1:0] cur,
    input  logic [PAGE_W-1:0] pages,
    output logic              fits,
    output logic [PAGE_W-1:0] cur_adv
);
    localparam int EXT_W = PAGE_W + 1;

    logic [EXT_W-1:0] size_e;
    logic [EXT_W-1:0] used_e;
    logic [EXT_W-1:0] free_e;
    logic [EXT_W-1:0] sum_e;
    logic [EXT_W-1:0] wrap_e;

    // Ring size and pages already holding unread data
    always_comb begin
        size_e = {1'b0, ring_stop} - {1'b0, ring_start};
        if (cur >= bnd)
            used_e = {1'b0, cur} - {1'b0, bnd};
        else
            used_e = size_e - ({1'b0, bnd} - {1'b0, cur});
        free_e = size_e - used_e;
        fits   = ({1'b0, pages} < free_e);
    end

    // Advance the write pointer with wrap at the end page
    always_comb begin
        sum_e  = {1'b0, cur} + {1'b0, pages};
        wrap_e = (sum_e >= {1'b0, ring_stop}) ? (sum_e - size_e) : sum_e;
        cur_adv = wrap_e[PAGE_W-1:0];
    end
endmodule

// File: rtl/rxr_sp_seq.sv
// rxr_sp_seq: send-packet sequencer. Fetches the header at the read pointer,
// launches the DMA with the stored count, then asks for the read pointer to
// take the header's next page once the DMA is done. Assumes the header
// reader and the DMA engine answer one request at a time.
module rxr_sp_seq #(
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              sp_cmd,
    input  logic              ring_empty,
    input  logic              hdr_valid,
    input  logic [31:0]       hdr_data,
    input  logic              dma_done,
    output logic              busy,
    output logic              hdr_req,
    output logic              dma_start,
    output logic [CNT_W-1:0]  dma_count,
    output logic              bnd_load,
    output logic [PAGE_W-1:0] bnd_next
);
    import rxr_pkg::*;

    sp_state_e state_q;
    rx_hdr_t   hdr_w;

    assign hdr_w = rx_hdr_t'(hdr_data);

    // State transitions of the send-packet sequence
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= SP_IDLE;
        end else begin
            case (state_q)
                SP_IDLE:   if (sp_cmd && !ring_empty) state_q <= SP_HDR;
                SP_HDR:    if (hdr_valid) state_q <= SP_LAUNCH;
                SP_LAUNCH: state_q <= SP_WAIT;
                SP_WAIT:   if (dma_done) state_q <= SP_IDLE;
                default:   state_q <= SP_IDLE;
            endcase
        end
    end

    // Capture the count and next page when the header arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_count <= '0;
            bnd_next  <= '0;
        end else if (state_q == SP_HDR && hdr_valid) begin
            dma_count <= CNT_W'({hdr_w.cnt_hi, hdr_w.cnt_lo});
            bnd_next  <= hdr_w.next_pg[PAGE_W-1:0];
        end
    end

    // Decode outputs from the state
    always_comb begin
        busy      = (state_q != SP_IDLE);
        hdr_req   = (state_q == SP_HDR);
        dma_start = (state_q == SP_LAUNCH);
        bnd_load  = (state_q == SP_WAIT) && dma_done && !abort;
    end
endmodule

// File: rtl/rxr_ring_mgr.sv
// rxr_ring_mgr: receive page ring manager. Holds the ring bounds and the two
// page pointers, accepts or refuses committed frames against free space, and
// runs the send-packet removal. Assumes init_stop > init_start and that the
// header next-page values lie inside the ring.
module rxr_ring_mgr #(
    parameter int          PAGE_W    = 8,
    parameter int          OFS_W     = 8,
    parameter int          CNT_W     = 16,
    parameter logic [7:0]  RST_START = 8'h26,
    parameter logic [7:0]  RST_STOP  = 8'h40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ring_init,
    input  logic [PAGE_W-1:0]       init_start,
    input  logic [PAGE_W-1:0]       init_stop,
    input  logic                    frm_commit,
    input  logic [PAGE_W-1:0]       frm_pages,
    input  logic                    ovf_clr,
    input  logic                    sp_cmd,
    output logic                    hdr_req,
    output logic [PAGE_W+OFS_W-1:0] hdr_addr,
    input  logic                    hdr_valid,
    input  logic [31:0]             hdr_data,
    output logic                    dma_start,
    output logic [PAGE_W+OFS_W-1:0] dma_addr,
    output logic [CNT_W-1:0]        dma_count,
    input  logic                    dma_done,
    output logic                    busy,
    output logic                    empty,
    output logic                    overflow,
    output logic [PAGE_W-1:0]       boundary,
    output logic [PAGE_W-1:0]       current
);
    localparam logic [OFS_W-1:0] PAGE_OFS0 = '0;

    logic [PAGE_W-1:0] start_q;
    logic [PAGE_W-1:0] stop_q;
    logic [PAGE_W-1:0] bnd_q;
    logic [PAGE_W-1:0] cur_q;
    logic              ovf_q;
    logic              fits;
    logic [PAGE_W-1:0] cur_adv;
    logic              bnd_load;
    logic [PAGE_W-1:0] bnd_next;
    logic              refuse;

    rxr_ring_space #(.PAGE_W(PAGE_W)) u_space (
        .ring_start (start_q),
        .ring_stop  (stop_q),
        .bnd        (bnd_q),
        .cur        (cur_q),
        .pages      (frm_pages),
        .fits       (fits),
        .cur_adv    (cur_adv)
    );

    rxr_sp_seq #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (ring_init),
        .sp_cmd     (sp_cmd),
        .ring_empty (empty),
        .hdr_valid  (hdr_valid),
        .hdr_data   (hdr_data),
        .dma_done   (dma_done),
        .busy       (busy),
        .hdr_req    (hdr_req),
        .dma_start  (dma_start),
        .dma_count  (dma_count),
        .bnd_load   (bnd_load),
        .bnd_next   (bnd_next)
    );

    assign refuse = frm_commit && !fits;

    // Ring bounds: reset defaults or values loaded by ring_init
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= PAGE_W'(RST_START);
            stop_q  <= PAGE_W'(RST_STOP);
        end else if (ring_init) begin
            start_q <= init_start;
            stop_q  <= init_stop;
        end
    end

    // Write pointer: advance on accepted commit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= PAGE_W'(RST_START);
        else if (ring_init)
            cur_q <= init_start;
        else if (frm_commit && fits)
            cur_q <= cur_adv;
    end

    // Read pointer: take the header next page at the end of a send-packet
    always_ff @(posedge clk) begin
        if (!rst_n)
            bnd_q <= PAGE_W'(RST_START);
        else if (ring_init)
            bnd_q <= init_start;
        else if (bnd_load)
            bnd_q <= bnd_next;
    end

    // Sticky overflow flag; a refusal wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n || ring_init)
            ovf_q <= 1'b0;
        else if (refuse)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    // Output mapping
    always_comb begin
        boundary = bnd_q;
        current  = cur_q;
        overflow = ovf_q;
        empty    = (bnd_q == cur_q);
        hdr_addr = {bnd_q, PAGE_OFS0};
        dma_addr = {bnd_q, PAGE_OFS0};
    end
endmodule

// File: rtl/rxr_ring_mgr_chk.sv
// rxr_ring_mgr_chk: temporal properties of the ring manager, bound to it.
module rxr_ring_mgr_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_init,
    input logic              frm_commit,
    input logic              sp_cmd,
    input logic              hdr_req,
    input logic              dma_start,
    input logic              busy,
    input logic              empty,
    input logic              overflow,
    input logic [PAGE_W-1:0] boundary,
    input logic [PAGE_W-1:0] current,
    input logic [PAGE_W-1:0] start_q,
    input logic [PAGE_W-1:0] stop_q
);
    // R9
    sp_empty_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_cmd && empty && !busy && !ring_init) |=> !busy);
    // R7
    dma_one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);
    // R6
    busy_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !empty);
    // R6
    hdr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req |-> busy);
    // R8
    bnd_move_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(boundary) && !$past(ring_init)) |-> $fell(busy));
    // R4
    cur_move_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(current) |-> ($past(frm_commit) || $past(ring_init)));
    // R5
    ovf_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(frm_commit));
    // R4
    cur_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q < stop_q) |-> (current >= start_q && current < stop_q));
endmodule

bind rxr_ring_mgr rxr_ring_mgr_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_init  (ring_init),
    .frm_commit (frm_commit),
    .sp_cmd     (sp_cmd),
    .hdr_req    (hdr_req),
    .dma_start  (dma_start),
    .busy       (busy),
    .empty      (empty),
    .overflow   (overflow),
    .boundary   (boundary),
    .current    (current),
    .start_q    (start_q),
    .stop_q     (stop_q)
);

// File: tb/rxr_ring_mgr_tb.sv
module rxr_ring_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ring_init = 1'b0;
    logic [7:0]  init_start = '0;
    logic [7:0]  init_stop = '0;
    logic        frm_commit = 1'b0;
    logic [7:0]  frm_pages = '0;
    logic        ovf_clr = 1'b0;
    logic        sp_cmd = 1'b0;
    logic        hdr_req;
    logic [15:0] hdr_addr;
    logic        hdr_valid = 1'b0;
    logic [31:0] hdr_data = '0;
    logic        dma_start;
    logic [15:0] dma_addr;
    logic [15:0] dma_count;
    logic        dma_done = 1'b0;
    logic        busy, empty, overflow;
    logic [7:0]  boundary, current;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_start = 'h26, m_stop = 'h40, m_bnd = 'h26, m_cur = 'h26;
    int m_ovf = 0, m_ph = 0, m_next = 0, m_cnt = 0;

    always #4 clk = ~clk;

    rxr_ring_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .ring_init(ring_init),
        .init_start(init_start), .init_stop(init_stop),
        .frm_commit(frm_commit), .frm_pages(frm_pages), .ovf_clr(ovf_clr),
        .sp_cmd(sp_cmd), .hdr_req(hdr_req), .hdr_addr(hdr_addr),
        .hdr_valid(hdr_valid), .hdr_data(hdr_data), .dma_start(dma_start),
        .dma_addr(dma_addr), .dma_count(dma_count), .dma_done(dma_done),
        .busy(busy), .empty(empty), .overflow(overflow),
        .boundary(boundary), .current(current)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        int size, free, old_bnd, old_cur, sum;
        bit refused;
        if (!rst_n) begin
            m_start = 'h26; m_stop = 'h40; m_bnd = 'h26; m_cur = 'h26;
            m_ovf = 0; m_ph = 0; m_next = 0; m_cnt = 0;
        end else if (ring_init) begin
            m_start = init_start; m_stop = init_stop;
            m_bnd = init_start; m_cur = init_start; m_ovf = 0; m_ph = 0;
        end else begin
            old_bnd = m_bnd; old_cur = m_cur;
            size = m_stop - m_start;
            if (old_bnd == old_cur) free = size;
            else if (old_bnd > old_cur) free = old_bnd - old_cur;
            else free = size - (old_cur - old_bnd);
            refused = frm_commit && (frm_pages >= free);
            if (frm_commit && !refused) begin
                sum = old_cur + frm_pages;
                m_cur = (sum >= m_stop) ? sum - size : sum;
            end
            if (refused) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            case (m_ph)
                0: if (sp_cmd && old_bnd != old_cur) m_ph = 1;
                1: if (hdr_valid) begin
                       m_ph = 2;
                       m_next = hdr_data[15:8];
                       m_cnt = {hdr_data[31:24], hdr_data[23:16]};
                   end
                2: m_ph = 3;
                default: if (dma_done) begin m_ph = 0; m_bnd = m_next; end
            endcase
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(boundary == m_bnd[7:0], "R8 boundary", boundary, m_bnd);
            check(current == m_cur[7:0], "R4 current", current, m_cur);
            check(empty == (m_bnd == m_cur), "R3 empty", empty, m_bnd == m_cur);
            check(overflow == m_ovf[0], "R5 overflow", overflow, m_ovf);
            check(busy == (m_ph != 0), "R6 busy", busy, m_ph != 0);
            check(hdr_req == (m_ph == 1), "R6 hdr_req", hdr_req, m_ph == 1);
            check(dma_start == (m_ph == 2), "R7 dma_start", dma_start, m_ph == 2);
            if (m_ph == 1)
                check(hdr_addr == {m_bnd[7:0], 8'h00}, "R6 hdr_addr", hdr_addr, m_bnd * 256);
            if (m_ph == 2) begin
                check(dma_addr == {m_bnd[7:0], 8'h00}, "R7 dma_addr", dma_addr, m_bnd * 256);
                check(dma_count == m_cnt[15:0], "R7 dma_count", dma_count, m_cnt);
            end
        end
    end

    task automatic commit(input int pages);
        @(negedge clk); frm_commit = 1'b1; frm_pages = 8'(pages);
        @(negedge clk); frm_commit = 1'b0;
    endtask

    task automatic init_ring(input int s, input int e);
        @(negedge clk); ring_init = 1'b1; init_start = 8'(s); init_stop = 8'(e);
        @(negedge clk); ring_init = 1'b0;
    endtask

    // full send-packet; optional commit in the dma_done cycle
    task automatic send(input int nxt, input int cnt, input int co_pages);
        @(negedge clk); sp_cmd = 1'b1;
        @(negedge clk); sp_cmd = 1'b0;
        repeat (2) @(negedge clk);
        hdr_valid = 1'b1;
        hdr_data = {8'(cnt >> 8), 8'(cnt), 8'(nxt), 8'h21};
        @(negedge clk); hdr_valid = 1'b0;
        repeat (3) @(negedge clk);
        dma_done = 1'b1;
        if (co_pages > 0) begin frm_commit = 1'b1; frm_pages = 8'(co_pages); end
        @(negedge clk); dma_done = 1'b0; frm_commit = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(boundary == 8'h26 && current == 8'h26, "R1 pointers", {boundary, current}, 16'h2626);
        check(empty && !overflow && !busy && !hdr_req && !dma_start, "R1 flags",
              {empty, overflow, busy, hdr_req, dma_start}, 5'b10000);
        rst_n = 1'b1;
        commit(5);
        // R2 init restores both pointers and clears overflow
        init_ring('h10, 'h18);
        check(boundary == 8'h10 && current == 8'h10, "R2 init pointers", {boundary, current}, 16'h1010);
        // R9 send-packet on empty ring is ignored
        @(negedge clk); sp_cmd = 1'b1;
        @(negedge clk); sp_cmd = 1'b0;
        check(!busy && !hdr_req, "R9 empty sp ignored", busy, 0);
        commit(3);
        commit(4);
        check(current == 8'h17, "R4 advance", current, 'h17);
        send('h13, 'h05A4, 0);
        check(boundary == 8'h13, "R8 next page taken", boundary, 'h13);
        commit(3);
        check(current == 8'h12, "R4 wrap", current, 'h12);
        commit(1);
        check(overflow && current == 8'h12, "R5 refuse full", current, 'h12);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check(!overflow, "R5 clear", overflow, 0);
        // R10 commit alongside the boundary move uses the old boundary
        send('h17, 'h0040, 2);
        check(overflow && current == 8'h12 && boundary == 8'h17, "R10 old boundary",
              {boundary, current}, 16'h1712);
        // R5 refusal wins over clear in the same cycle
        @(negedge clk); ovf_clr = 1'b1; frm_commit = 1'b1; frm_pages = 8'd9;
        @(negedge clk); ovf_clr = 1'b0; frm_commit = 1'b0;
        check(overflow, "R5 set beats clear", overflow, 1);
        // R9 second sp while busy ignored
        @(negedge clk); sp_cmd = 1'b1;
        @(negedge clk); sp_cmd = 1'b1;
        @(negedge clk); sp_cmd = 1'b0;
        hdr_valid = 1'b1; hdr_data = 32'h0100_1221;
        @(negedge clk); hdr_valid = 1'b0;
        repeat (2) @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        @(negedge clk);
        check(!busy && boundary == 8'h12 && empty, "R9 busy sp ignored", boundary, 'h12);
        // R2 init aborts a running send
        commit(2);
        @(negedge clk); sp_cmd = 1'b1;
        @(negedge clk); sp_cmd = 1'b0;
        init_ring('h40, 'h60);
        check(!busy && !hdr_req && boundary == 8'h40 && current == 8'h40 && !overflow,
              "R2 abort", busy, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule